// File: doc/BRIEF.md
# Interrupt Redirection Entry Controller

This block manages one interrupt input pin together with its 64-bit redirection entry. Software programs the entry through a 32-bit register port, one half at a time, selecting the half with a single select bit. The entry holds the vector, delivery mode, destination mode, input polarity, trigger mode, mask and an 8-bit destination. The block watches the pin after polarity inversion and decides, once per clock, whether to issue a delivery request. When it issues one, it presents the entry's routing fields on a registered request bus for one cycle.

Edge-triggered entries fire on each rising edge of the inverted pin. Level-triggered entries fire while the pin is asserted, but each request sets a remote-pending flag that blocks further requests until an end-of-interrupt with the matching vector arrives. A small two-state machine holds that flag: `RP_IDLE` (no delivery outstanding) and `RP_WAIT_EOI` (a level delivery outstanding). The transition `RP_IDLE -> RP_WAIT_EOI` happens when a level request is issued. The transition `RP_WAIT_EOI -> RP_IDLE` happens on a matching end-of-interrupt, or when software rewrites the low half with the trigger bit cleared. Because the level condition is evaluated every cycle, rewriting the entry (for example unmasking it) while the pin is asserted sends at once. A write that changes any field other than mask and polarity raises a one-cycle pulse, so downstream trigger-mode bookkeeping can refresh itself.

Top module: `irq_redir_entry`

## Requirements
- R1: After reset the low half reads 0x00010000 (masked, all else zero), the high half reads 0, and `req_valid` and `tmr_changed` are low.
- R2: While mask bit 16 is set, no request is issued, whatever the pin does and even after the remote-pending flag is released.
- R3: With trigger bit 15 clear (edge), one request with `req_level`=0 is issued, in the cycle after the clock edge that sees the inverted pin rise, and no request follows while it stays high. Remote-pending bit 14 always reads 0 in this mode.
- R4: With trigger bit 15 set (level), an unmasked and asserted pin with remote-pending clear gives a request with `req_level`=1, and sets the flag (bit 14 reads 1). No further request follows while the flag is set.
- R5: An end-of-interrupt whose vector equals bits [7:0] clears the remote-pending flag, and a non-matching vector has no effect. If the level pin is still asserted and unmasked, a new request follows one cycle after the flag clears.
- R6: A request carries vector = bits [7:0], destination = bits [63:56], `req_dest_logical` = bit 11, delivery mode = bits [10:8], and `req_level` = bit 15.
- R7: A write with `reg_sel`=0 changes only bits [31:0] and one with `reg_sel`=1 changes only bits [63:32]. Bits 12 and 14 ignore the written data.
- R8: A low-half write with bit 15 clear clears the remote-pending flag.
- R9: A write that leaves a level entry unmasked, with the pin asserted and the flag clear, produces a request with no new pin activity.
- R10: A write that changes any bit other than 16 (mask) and 13 (polarity) pulses `tmr_changed` for one cycle after the write edge. A write that changes only those bits does not.
- R11: Polarity bit 13 set inverts the pin, so a falling `irq_pin` counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 1 | Interrupt pin, synchronous to clk |
| reg_wr | input | 1 | Write strobe for the addressed half |
| reg_sel | input | 1 | Half select: 0 = bits [31:0], 1 = bits [63:32] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Addressed half, with the live remote-pending flag in bit 14 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| req_valid | output | 1 | Delivery request, one cycle per request |
| req_vector | output | 8 | Vector of the request |
| req_dest | output | 8 | Destination of the request |
| req_dest_logical | output | 1 | 1 = logical destination, 0 = physical |
| req_del_mode | output | 3 | Delivery mode of the request |
| req_level | output | 1 | 1 = level-triggered request |
| tmr_changed | output | 1 | Pulse: a field other than mask or polarity changed |

## Verification
The properties assume that `irq_pin`, `eoi_valid` and the register strobes are synchronous to `clk`, and that each write and end-of-interrupt is a single-cycle pulse seen at one rising edge. The stimulus changes every input only on the falling edge, keeps each strobe high for exactly one cycle, and samples the outputs on the next falling edge. The scoreboard is loaded with the exact expected request before the stimulus that causes it, so any extra, missing or mis-routed request shows up.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int HALF_W   = 32;
    localparam int ENTRY_W  = 2 * HALF_W;
    localparam int VEC_W    = 8;
    localparam int DEST_W   = 8;
    localparam int DM_W     = 3;

    // Bit positions inside the 64-bit entry
    localparam int POS_VEC     = 0;
    localparam int POS_DM      = 8;
    localparam int POS_DESTLOG = 11;
    localparam int POS_BUSY    = 12;
    localparam int POS_POL     = 13;
    localparam int POS_RP      = 14;
    localparam int POS_TRIG    = 15;
    localparam int POS_MASK    = 16;
    localparam int POS_DEST    = ENTRY_W - DEST_W;
    localparam int POS_DEST_HI = POS_DEST - HALF_W;

    typedef enum logic [0:0] {
        RP_IDLE     = 1'b0,
        RP_WAIT_EOI = 1'b1
    } rp_state_t;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [DEST_W-1:0] dest;
        logic              dest_logical;
        logic [DM_W-1:0]   del_mode;
        logic              level;
    } redir_req_t;

endpackage

// File: rtl/redir_entry_regs.sv
module redir_entry_regs
    import irq_redir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic              rp_flag,
    output logic [HALF_W-1:0] rd_data,
    output logic [VEC_W-1:0]  f_vector,
    output logic [DM_W-1:0]   f_del_mode,
    output logic              f_dest_logical,
    output logic              f_polarity,
    output logic              f_level,
    output logic              f_mask,
    output logic [DEST_W-1:0] f_dest,
    output logic              edge_wr,
    output logic              tmr_pulse
);

    localparam logic [HALF_W-1:0] RO_LO =
        (HALF_W'(1) << POS_BUSY) | (HALF_W'(1) << POS_RP);
    localparam logic [HALF_W-1:0] QUIET_LO =
        RO_LO | (HALF_W'(1) << POS_MASK) | (HALF_W'(1) << POS_POL);
    localparam logic [ENTRY_W-1:0] RESET_VAL = ENTRY_W'(1) << POS_MASK;

    logic [HALF_W-1:0] half_q [2];
    logic [1:0]        half_changed;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [HALF_W-1:0] RO_BITS = (h == 0) ? RO_LO : '0;
        localparam logic [HALF_W-1:0] QUIET   = (h == 0) ? QUIET_LO : '0;
        localparam logic [HALF_W-1:0] RST     = RESET_VAL[h*HALF_W +: HALF_W];

        logic [HALF_W-1:0] q;
        logic [HALF_W-1:0] nxt;
        logic              hit;

        assign hit = wr_en && (wr_sel == 1'(h));
        assign nxt = (wr_data & ~RO_BITS) | (q & RO_BITS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST;
            end else if (hit) begin
                q <= nxt;
            end
        end

        assign half_changed[h] = hit && (((q ^ nxt) & ~QUIET) != '0);
        assign half_q[h]       = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_pulse <= 1'b0;
        end else begin
            tmr_pulse <= |half_changed;
        end
    end

    assign edge_wr = wr_en && !wr_sel && !wr_data[POS_TRIG];

    always_comb begin
        rd_data = half_q[rd_sel];
        if (!rd_sel) begin
            rd_data[POS_RP] = rp_flag;
        end
    end

    assign f_vector       = half_q[0][POS_VEC +: VEC_W];
    assign f_del_mode     = half_q[0][POS_DM +: DM_W];
    assign f_dest_logical = half_q[0][POS_DESTLOG];
    assign f_polarity     = half_q[0][POS_POL];
    assign f_level        = half_q[0][POS_TRIG];
    assign f_mask         = half_q[0][POS_MASK];
    assign f_dest         = half_q[1][POS_DEST_HI +: DEST_W];

endmodule

// File: rtl/redir_pin_front.sv
module redir_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic polarity,
    output logic asserted,
    output logic rise
);

    logic asserted_q;

    assign asserted = pin ^ polarity;
    assign rise     = asserted && !asserted_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asserted_q <= 1'b0;
        end else begin
            asserted_q <= asserted;
        end
    end

endmodule

// File: rtl/redir_pending_fsm.sv
module redir_pending_fsm
    import irq_redir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_sent,
    input  logic eoi_hit,
    input  logic edge_wr,
    output logic rp_flag
);

    rp_state_t state_q;
    rp_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // A switch to edge triggering wins over a level send in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: begin
                if (level_sent && !edge_wr) begin
                    state_d = RP_WAIT_EOI;
                end
            end
            RP_WAIT_EOI: begin
                if (eoi_hit || edge_wr) begin
                    state_d = RP_IDLE;
                end
            end
            default: state_d = RP_IDLE;
        endcase
    end

    always_comb begin
        rp_flag = (state_q == RP_WAIT_EOI);
    end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic              eoi_valid,
    input  logic [VEC_W-1:0]  eoi_vector,
    output logic              req_valid,
    output logic [VEC_W-1:0]  req_vector,
    output logic [DEST_W-1:0] req_dest,
    output logic              req_dest_logical,
    output logic [DM_W-1:0]   req_del_mode,
    output logic              req_level,
    output logic              tmr_changed
);

    logic [VEC_W-1:0]  f_vector;
    logic [DM_W-1:0]   f_del_mode;
    logic              f_dest_logical;
    logic              f_polarity;
    logic              entry_level;
    logic              entry_mask;
    logic [DEST_W-1:0] f_dest;
    logic              edge_wr;
    logic              rp_flag;
    logic              pin_asserted;
    logic              pin_rise;
    logic              edge_fire;
    logic              level_fire;
    logic              eoi_hit;
    redir_req_t        req_d;
    redir_req_t        req_q;
    logic              req_valid_q;

    redir_entry_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (reg_wr),
        .wr_sel         (reg_sel),
        .wr_data        (reg_wdata),
        .rd_sel         (reg_sel),
        .rp_flag        (rp_flag),
        .rd_data        (reg_rdata),
        .f_vector       (f_vector),
        .f_del_mode     (f_del_mode),
        .f_dest_logical (f_dest_logical),
        .f_polarity     (f_polarity),
        .f_level        (entry_level),
        .f_mask         (entry_mask),
        .f_dest         (f_dest),
        .edge_wr        (edge_wr),
        .tmr_pulse      (tmr_changed)
    );

    redir_pin_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (irq_pin),
        .polarity (f_polarity),
        .asserted (pin_asserted),
        .rise     (pin_rise)
    );

    redir_pending_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_sent (level_fire),
        .eoi_hit    (eoi_hit),
        .edge_wr    (edge_wr),
        .rp_flag    (rp_flag)
    );

    assign edge_fire  = !entry_level && !entry_mask && pin_rise;
    assign level_fire = entry_level && !entry_mask && pin_asserted && !rp_flag;
    assign eoi_hit    = eoi_valid && (eoi_vector == f_vector);

    always_comb begin
        req_d.vector       = f_vector;
        req_d.dest         = f_dest;
        req_d.dest_logical = f_dest_logical;
        req_d.del_mode     = f_del_mode;
        req_d.level        = entry_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid_q <= 1'b0;
            req_q       <= '0;
        end else begin
            req_valid_q <= edge_fire || level_fire;
            if (edge_fire || level_fire) begin
                req_q <= req_d;
            end
        end
    end

    assign req_valid        = req_valid_q;
    assign req_vector       = req_q.vector;
    assign req_dest         = req_q.dest;
    assign req_dest_logical = req_q.dest_logical;
    assign req_del_mode     = req_q.del_mode;
    assign req_level        = req_q.level;

endmodule

// File: rtl/irq_redir_entry_chk.sv
module irq_redir_entry_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_level,
    input logic reg_wr,
    input logic tmr_changed,
    input logic entry_mask,
    input logic entry_level,
    input logic rp_flag
);

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(!entry_mask)); // R2

    AST_RP_ONLY_BY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rp_flag) |-> (req_valid && req_level)); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_flag && entry_level) |=> !(req_valid && req_level)); // R4

    AST_RP_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level && entry_level) |-> rp_flag); // R4

    AST_EDGE_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rp_flag |-> entry_level); // R8

    AST_TMR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_changed |-> $past(reg_wr)); // R10

endmodule

bind irq_redir_entry irq_redir_entry_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_level   (req_level),
    .reg_wr      (reg_wr),
    .tmr_changed (tmr_changed),
    .entry_mask  (entry_mask),
    .entry_level (entry_level),
    .rp_flag     (rp_flag)
);

// File: tb/irq_redir_entry_bench.sv
module irq_redir_entry_bench;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
        logic       dest_logical;
        logic [2:0] del_mode;
        logic       level;
    } exp_req_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        req_valid;
    logic [7:0]  req_vector;
    logic [7:0]  req_dest;
    logic        req_dest_logical;
    logic [2:0]  req_del_mode;
    logic        req_level;
    logic        tmr_changed;

    int total = 0;
    int bad   = 0;
    exp_req_t exp_q [$];

    always #10 clk = ~clk;

    irq_redir_entry u_irq_redir_entry (
        .clk              (clk),
        .rst_n            (rst_n),
        .irq_pin          (irq_pin),
        .reg_wr           (reg_wr),
        .reg_sel          (reg_sel),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .eoi_valid        (eoi_valid),
        .eoi_vector       (eoi_vector),
        .req_valid        (req_valid),
        .req_vector       (req_vector),
        .req_dest         (req_dest),
        .req_dest_logical (req_dest_logical),
        .req_del_mode     (req_del_mode),
        .req_level        (req_level),
        .tmr_changed      (tmr_changed)
    );

    // Monitor: every request must match the head of the scoreboard (R3 R4 R6)
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            exp_req_t got;
            got = '{req_vector, req_dest, req_dest_logical, req_del_mode, req_level};
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2/R3/R4 unexpected request: actual=%h expected=none", got);
            end else begin
                exp_req_t want;
                want = exp_q.pop_front();
                if (got !== want) begin
                    bad++;
                    $display("FAIL R6 request fields: actual=%h expected=%h", got, want);
                end
            end
        end
    end

    task automatic expect_req(input logic [7:0] vec, input logic [7:0] dst,
                              input logic lg, input logic [2:0] dm, input logic lv);
        exp_q.push_back('{vec, dst, lg, dm, lv});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL %s missing request: actual=%0d pending expected=0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data,
                      input logic exp_tmr, input string tag);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        total++;
        if (tmr_changed !== exp_tmr) begin
            bad++;
            $display("FAIL %s tmr_changed: actual=%b expected=%b", tag, tmr_changed, exp_tmr);
        end
    endtask

    task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s read half %0d: actual=%h expected=%h", tag, sel, reg_rdata, exp);
        end
    endtask

    task automatic eoi(input logic [7:0] vec);
        eoi_valid = 1'b1;
        eoi_vector = vec;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        rd(1'b0, 32'h0001_0000, "R1");
        rd(1'b1, 32'h0000_0000, "R1");
        total++;
        if (req_valid !== 1'b0 || tmr_changed !== 1'b0) begin
            bad++;
            $display("FAIL R1 outputs idle: actual=%b%b expected=00", req_valid, tmr_changed);
        end

        // R7 R10 high half: destination 0xA5
        wr(1'b1, 32'hA500_0000, 1'b1, "R10");
        rd(1'b1, 32'hA500_0000, "R7");
        rd(1'b0, 32'h0001_0000, "R7");
        // R7 low half, attempt to set read-only bits 12 and 14
        wr(1'b0, 32'h0000_5A41, 1'b1, "R10");
        rd(1'b0, 32'h0000_0A41, "R7");

        // R3 edge mode: one request per rising edge
        expect_req(8'h41, 8'hA5, 1'b1, 3'd2, 1'b0);
        irq_pin = 1'b1;
        cycles(4);
        drained("R3");
        rd(1'b0, 32'h0000_0A41, "R3");
        irq_pin = 1'b0;
        cycles(1);
        expect_req(8'h41, 8'hA5, 1'b1, 3'd2, 1'b0);
        irq_pin = 1'b1;
        cycles(2);
        drained("R3");
        irq_pin = 1'b0;
        cycles(1);

        // R2 R10 mask only write: no pulse, no request
        wr(1'b0, 32'h0001_0A41, 1'b0, "R10");
        irq_pin = 1'b1;
        cycles(2);
        irq_pin = 1'b0;
        cycles(2);
        drained("R2");

        // R11 polarity inverted: unmask with pin low gives a rise
        expect_req(8'h41, 8'hA5, 1'b1, 3'd2, 1'b0);
        wr(1'b0, 32'h0000_2A41, 1'b0, "R10");
        cycles(2);
        drained("R11");
        irq_pin = 1'b1;
        cycles(2);
        drained("R11");
        expect_req(8'h41, 8'hA5, 1'b1, 3'd2, 1'b0);
        irq_pin = 1'b0;
        cycles(2);
        drained("R11");

        // R4 R9 level mode, masked then unmasked while asserted
        wr(1'b0, 32'h0001_8062, 1'b1, "R10");
        irq_pin = 1'b1;
        cycles(2);
        drained("R2");
        expect_req(8'h62, 8'hA5, 1'b0, 3'd0, 1'b1);
        wr(1'b0, 32'h0000_8062, 1'b0, "R9");
        cycles(4);
        drained("R9");
        rd(1'b0, 32'h0000_C062, "R4");

        // R5 non-matching then matching end-of-interrupt
        eoi(8'h63);
        cycles(2);
        rd(1'b0, 32'h0000_C062, "R5");
        expect_req(8'h62, 8'hA5, 1'b0, 3'd0, 1'b1);
        eoi(8'h62);
        cycles(3);
        drained("R5");
        rd(1'b0, 32'h0000_C062, "R5");
        irq_pin = 1'b0;
        cycles(1);
        eoi(8'h62);
        cycles(2);
        rd(1'b0, 32'h0000_8062, "R5");

        // R8 switch to edge clears remote-pending
        expect_req(8'h62, 8'hA5, 1'b0, 3'd0, 1'b1);
        irq_pin = 1'b1;
        cycles(2);
        drained("R4");
        rd(1'b0, 32'h0000_C062, "R4");
        wr(1'b0, 32'h0000_0062, 1'b1, "R8");
        rd(1'b0, 32'h0000_0062, "R8");
        cycles(3);
        drained("R8");

        // R9 back to level while asserted resends
        expect_req(8'h62, 8'hA5, 1'b0, 3'd0, 1'b1);
        wr(1'b0, 32'h0000_8062, 1'b1, "R9");
        cycles(2);
        drained("R9");
        rd(1'b0, 32'h0000_C062, "R9");

        // R2 masked level entry: flag released, no resend
        wr(1'b0, 32'h0001_8062, 1'b0, "R2");
        eoi(8'h62);
        cycles(3);
        drained("R2");
        rd(1'b0, 32'h0001_8062, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule